// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides an unsigned dividend by an unsigned divisor of the same width, one quotient bit per clock cycle. It uses the shift-and-subtract method. While the block is idle, the dividend and divisor are written through separate load strobes. A start request then launches the computation.

On each compute cycle the remainder and the dividend move left together as one long register. The dividend's top bit enters the remainder's low end, and a ripple subtractor forms the trial difference against the divisor. The subtractor's carry-out gives the quotient bit. That bit fills the vacated low bit of the dividend register, which becomes the quotient register over the run. The same carry-out also decides whether the remainder takes the difference or keeps its shifted value.

After exactly `N` compute cycles the block raises `done`. It holds `done`, with the results, until the start request is removed. The results stay on the outputs after the block returns to idle, until the next start.

Top module: `seq_divider`

## Requirements
- R1: A synchronous active-low reset puts the block in idle with `done` = 0, `quot` = 0 and `rem` = 0, and also clears the held divisor.
- R2: For any divisor other than zero, a run ends with `quot` equal to the integer quotient and `rem` equal to the remainder of the loaded operands. For example, 140 divided by 9 with N = 8 gives 15 and 5.
- R3: `done` first reads 1 after the (N+1)-th rising edge counted from the edge at which `start` = 1 is sampled in idle. That edge moves the block to computing, and N compute edges follow it.
- R4: While `done` = 1 and `start` stays 1, `done` stays 1 and the results are unchanged. One edge after `start` is sampled as 0, `done` returns to 0 and the block is idle.
- R5: `load_a` and `load_b` take effect only in idle. A strobe that arrives while the block is computing or done changes neither the result of the current run nor the outputs.
- R6: When the dividend is smaller than the divisor, `quot` = 0 and `rem` equals the dividend. A divisor of 1 gives `quot` equal to the dividend and `rem` = 0.
- R7: A divisor of zero gives `quot` = all ones and `rem` equal to the dividend. No separate flag is raised.
- R8: After the block returns to idle, `quot` and `rem` keep their final values until the next start. Starting again clears the remainder register.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start request; held high until the result has been taken |
| load_a | input | 1 | Write strobe for the dividend (honoured in idle only) |
| data_a | input | N | Dividend value |
| load_b | input | 1 | Write strobe for the divisor (honoured in idle only) |
| data_b | input | N | Divisor value |
| quot | output | N | Quotient (the dividend register) |
| rem | output | N | Remainder |
| done | output | 1 | Result valid; held while `start` stays high |

## Verification
The hardest case to reach from the ports is a load strobe that arrives while the block is busy. This is the only route by which the operands of a run in progress could be corrupted. The stimulus raises `start`, waits a few edges into the computation, and then pulses both load strobes with unrelated values. It checks that the finished quotient and remainder still match the original operands. The stimulus repeats the pulse while `done` is held, and checks that the outputs do not move. Extremes such as a zero divisor and full-scale operands push every trial subtraction to one side, so every carry-out is 1 or every carry-out is 0.

// File: rtl/div_pkg.sv
// Package: shared controller state encoding for the sequential divider.
// Assumes: included first in compile order.
package div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_t;
endpackage

// File: rtl/div_sub.sv
// Module: div_sub
// Forms a - b for an (N+1)-bit a and an N-bit b.
// It adds a, the inverted zero-extended b and a carry-in of 1.
// The carry-out is 1 exactly when a >= b.
// Assumes: both operands are unsigned.
module div_sub #(
    parameter int N = 8
) (
    input  logic [N:0]   a,
    input  logic [N-1:0] b,
    output logic [N:0]   diff,
    output logic         cout
);
    logic [N+1:0] carry;
    logic [N:0]   b_inv;

    assign carry[0] = 1'b1;

    genvar i;
    generate
        for (i = 0; i <= N; i++) begin : g_bit
            // Invert the divisor bit; the extension bit above it inverts to 1.
            if (i < N) begin : g_data
                assign b_inv[i] = ~b[i];
            end else begin : g_ext
                assign b_inv[i] = 1'b1;
            end
            // One full-adder stage of the ripple chain.
            assign diff[i]    = a[i] ^ b_inv[i] ^ carry[i];
            assign carry[i+1] = (a[i] & b_inv[i]) | (a[i] & carry[i]) | (b_inv[i] & carry[i]);
        end
    endgenerate

    assign cout = carry[N+1];
endmodule

// File: rtl/div_ctrl.sv
// Module: div_ctrl
// Three-state controller for the divider: idle/load, compute, done.
// The bit counter is preset to N-1 while the block is idle.
// The counter steps down once per compute cycle, and the controller
// leaves the compute state on the cycle the counter reads zero.
// Assumes: N >= 2; rst_n is synchronous and active low.
module div_ctrl
    import div_pkg::*;
#(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ld_en,
    output logic clr_r,
    output logic shift_en,
    output logic done
);
    localparam int CW = (N > 2) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    div_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start)          state_d = ST_RUN;
            ST_RUN:  if (cnt_q == '0)    state_d = ST_FIN;
            ST_FIN:  if (!start)         state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Bit counter: preset in idle, decremented while computing.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= LAST;
        else if (state_q == ST_IDLE) cnt_q <= LAST;
        else if (state_q == ST_RUN)  cnt_q <= cnt_q - CW'(1);
    end

    // Datapath strobes decoded from the current state.
    always_comb begin
        ld_en    = (state_q == ST_IDLE);
        clr_r    = (state_q == ST_IDLE) && start;
        shift_en = (state_q == ST_RUN);
        done     = (state_q == ST_FIN);
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R3

    AST_RUN_STARTS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> (state_q == ST_RUN && cnt_q == LAST)); // R3

    AST_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(state_q == ST_RUN)); // R3

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> done); // R4

    AST_DONE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (!done && ld_en)); // R4
endmodule

// File: rtl/div_datapath.sv
// Module: div_datapath
// Holds the divisor, the dividend/quotient register and the remainder.
// On each shift cycle, the remainder concatenated with the dividend's top
// bit is compared with the divisor, through the subtractor's carry-out.
// The remainder takes the difference or the shifted value, and the
// carry-out enters the low end of the dividend register.
// Assumes: ld_en and shift_en are never high together.
module div_datapath #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_en,
    input  logic         clr_r,
    input  logic         shift_en,
    input  logic         load_a,
    input  logic [N-1:0] data_a,
    input  logic         load_b,
    input  logic [N-1:0] data_b,
    output logic [N-1:0] quot,
    output logic [N-1:0] rem
);
    logic [N-1:0] a_q, b_q, r_q;
    logic [N:0]   trial, diff;
    logic         ge;

    // Trial remainder: the remainder moved left, with the dividend's top bit entering.
    assign trial = {r_q, a_q[N-1]};

    div_sub #(.N(N)) i_sub (
        .a    (trial),
        .b    (b_q),
        .diff (diff),
        .cout (ge)
    );

    // Divisor register, writable only in idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                b_q <= '0;
        else if (ld_en && load_b)  b_q <= data_b;
    end

    // Dividend register, which fills with quotient bits while computing.
    always_ff @(posedge clk) begin
        if (!rst_n)                a_q <= '0;
        else if (ld_en && load_a)  a_q <= data_a;
        else if (shift_en)         a_q <= {a_q[N-2:0], ge};
    end

    // Remainder register: cleared at start, then restored or subtracted.
    always_ff @(posedge clk) begin
        if (!rst_n)        r_q <= '0;
        else if (clr_r)    r_q <= '0;
        else if (shift_en) r_q <= ge ? diff[N-1:0] : trial[N-1:0];
    end

    assign quot = a_q;
    assign rem  = r_q;

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && b_q != '0) |=> (r_q < b_q)); // R2

    AST_DIVISOR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> $stable(b_q)); // R5

    AST_NO_DUAL_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_en && shift_en)); // R5
endmodule

// File: rtl/seq_divider.sv
// Module: seq_divider (top)
// Unsigned N-bit restoring divider that produces one quotient bit per clock.
// The quotient appears on quot and the remainder on rem when done is high.
// Assumes: operands are loaded in idle; start is held until the result is taken.
module seq_divider #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         load_a,
    input  logic [N-1:0] data_a,
    input  logic         load_b,
    input  logic [N-1:0] data_b,
    output logic [N-1:0] quot,
    output logic [N-1:0] rem,
    output logic         done
);
    logic ld_en, clr_r, shift_en;

    div_ctrl #(.N(N)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .ld_en    (ld_en),
        .clr_r    (clr_r),
        .shift_en (shift_en),
        .done     (done)
    );

    div_datapath #(.N(N)) i_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .clr_r    (clr_r),
        .shift_en (shift_en),
        .load_a   (load_a),
        .data_a   (data_a),
        .load_b   (load_b),
        .data_b   (data_b),
        .quot     (quot),
        .rem      (rem)
    );

    AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> ($stable(quot) && $stable(rem))); // R4
endmodule

// File: tb/test_seq_divider.sv
module test_seq_divider;
    localparam int N = 8;
    localparam int MAXV = (1 << N) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         load_a = 1'b0, load_b = 1'b0;
    logic [N-1:0] data_a = '0, data_b = '0;
    logic [N-1:0] quot, rem;
    logic         done;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    seq_divider #(.N(N)) i_seq_divider (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load_a(load_a), .data_a(data_a),
        .load_b(load_b), .data_b(data_b),
        .quot(quot), .rem(rem), .done(done)
    );

    always #4 clk = ~clk;

    // Watchdog: counts as a failed check and still prints the summary.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                bad++;
                total++;
                $display("FAIL watchdog: actual=%0d cycles expected<=20000", cyc);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_ops(input int a, input int b);
        @(negedge clk);
        load_a = 1'b1; data_a = N'(a);
        load_b = 1'b1; data_b = N'(b);
        @(negedge clk);
        load_a = 1'b0; load_b = 1'b0;
    endtask

    // Raise start and count edges until done; returns the edge count.
    task automatic wait_done(output int edges);
        edges = 0;
        start = 1'b1;
        do begin
            @(negedge clk);
            edges++;
        end while (!done && edges < 60);
    endtask

    // Release start, then check done falls and the results persist.
    task automatic finish_run(input int eq, input int er);
        start = 1'b0;
        @(negedge clk);
        check("R4 done drops", int'(done), 0);
        @(negedge clk);
        check("R8 quot held in idle", int'(quot), eq);
        check("R8 rem held in idle", int'(rem), er);
    endtask

    task automatic run_div(input string req, input int a, input int b);
        int edges, eq, er;
        eq = (b == 0) ? MAXV : a / b;
        er = (b == 0) ? a : a % b;
        load_ops(a, b);
        wait_done(edges);
        check({req, " latency"}, edges, N + 1);
        check({req, " quotient"}, int'(quot), eq);
        check({req, " remainder"}, int'(rem), er);
        finish_run(eq, er);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R1 done after reset", int'(done), 0);
        check("R1 quot after reset", int'(quot), 0);
        check("R1 rem after reset", int'(rem), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_hold;
        int edges;
        load_ops(200, 7);
        wait_done(edges);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R4 done held", int'(done), 1);
            check("R4 quot held", int'(quot), 28);
        end
        finish_run(28, 4);
    endtask

    task automatic t_busy_loads;
        int edges;
        load_ops(140, 9);
        start = 1'b1;
        @(negedge clk); @(negedge clk); @(negedge clk);
        load_a = 1'b1; data_a = 8'd3; load_b = 1'b1; data_b = 8'd1;
        @(negedge clk);
        load_a = 1'b0; load_b = 1'b0;
        do begin
            @(negedge clk);
        end while (!done && cyc < 19000);
        check("R5 quotient despite busy load", int'(quot), 15);
        check("R5 remainder despite busy load", int'(rem), 5);
        load_a = 1'b1; data_a = 8'd99; load_b = 1'b1; data_b = 8'd2;
        @(negedge clk);
        load_a = 1'b0; load_b = 1'b0;
        @(negedge clk);
        check("R5 quot unchanged by load in done", int'(quot), 15);
        check("R5 rem unchanged by load in done", int'(rem), 5);
        finish_run(15, 5);
        // Re-run without reloading: the dividend is now 15 and the divisor must still be 9.
        wait_done(edges);
        check("R5 divisor kept after done-time load", int'(quot), 1);
        check("R8 restart clears remainder", int'(rem), 6);
        finish_run(1, 6);
    endtask

    task automatic t_reset_midrun;
        load_ops(250, 3);
        start = 1'b1;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1'b0;
        start = 1'b0;
        @(negedge clk);
        check("R1 done after mid-run reset", int'(done), 0);
        check("R1 quot after mid-run reset", int'(quot), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        run_div("R2 140/9", 140, 9);
        run_div("R3 255/13", 255, 13);
        run_div("R6 7/200", 7, 200);
        run_div("R6 201/1", 201, 1);
        run_div("R6 0/5", 0, 5);
        run_div("R2 255/255", 255, 255);
        run_div("R7 77/0", 77, 0);
        run_div("R7 255/0", 255, 0);
        for (int i = 0; i < 6; i++) begin
            run_div("R2 sweep", (i * 47 + 19) % 256, i * 29 + 3);
        end
        t_hold();
        t_busy_loads();
        t_reset_midrun();
        run_div("R2 after reset 100/10", 100, 10);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule